// File: doc/BRIEF.md
# PCI Target Single-Beat Read Sequencer

This block answers a single-beat PCI read aimed at memory whose page is already open. While it is idle, an address latch follows the AD bus on every clock. On the clock where FRAME# is seen active together with an address-decode hit, the sequencer drops its address/data select output. That freezes the latch and starts the response. After one turnaround clock it claims the cycle: it drives DEVSEL# low, drives TRDY# and STOP# high, and turns on the AD drivers. It then waits a fixed number of clocks, which stand in for the DRAM column access. After that wait it asserts TRDY# for one clock, with the memory word placed on the AD output.

The clock after the data beat, the handshake signals return high and the AD drivers turn off. One clock later the handshake signals float and the address latch is reopened. On that same release clock, an arbiter input decides how three shared-bus controls are handed off: the memory-path select, the CPU address output enable and the address acknowledge. If the master keeps the grant they are held. Otherwise they are released. Each three-state pin is modelled as a value bit paired with an enable bit.

Top module: `pci_tgt_rd_seq`

## Requirements
- R1: During reset, adsel is 1, ad_oe is 0, all three target enables and aack_oe are 0, and sel_n and cpu_addr_oe_n are 1.
- R2: While adsel is 1, ad_q loads ad_in on every rising edge. While adsel is 0, ad_q holds the address captured on the edge where FRAME# was seen.
- R3: On an edge with frame_n = 0 and addr_hit = 1 while idle, adsel goes to 0 (edge 1 of the transaction).
- R4: On edge 2 the block drives devsel_n = 0, trdy_n = 1 and stop_n = 1, each with its enable at 1. On the same edge ad_oe goes to 1, sel_n and cpu_addr_oe_n go to 0, and aack is driven at 1.
- R5: On edge 2+LAT, trdy_n goes to 0 for exactly one clock, and ad_out carries the mem_data value sampled on that edge. trdy_n stays 1 between edge 2 and that edge.
- R6: On edge 3+LAT, trdy_n, devsel_n and stop_n are 1 and still driven, and ad_oe is 0.
- R7: On edge 4+LAT, the enables of TRDY#, DEVSEL# and STOP# go to 0 and adsel returns to 1.
- R8: If keep_grant is 1 on edge 4+LAT, sel_n and cpu_addr_oe_n stay 0 and aack stays driven at 1.
- R9: If keep_grant is 0 on edge 4+LAT, sel_n and cpu_addr_oe_n go to 1 and aack_oe goes to 0.
- R10: frame_n = 0 with addr_hit = 0 leaves the block idle: adsel stays 1 and no target signal or AD driver is enabled.
- R11: frame_n and keep_grant have no effect at any edge other than an idle edge (for frame_n) or the release edge (for keep_grant). No second claim follows a release unless FRAME# is seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | FRAME#, active low |
| addr_hit | input | 1 | Address decode hit, sampled with FRAME# |
| keep_grant | input | 1 | Arbiter: 1 when the master keeps the grant |
| ad_in | input | AW | AD bus as seen by the address latch |
| mem_data | input | DW | Word from memory |
| adsel | output | 1 | Address/data select: 1 lets the latch follow the bus |
| ad_q | output | AW | Latched PCI address |
| ad_out | output | DW | Read data presented on AD |
| ad_oe | output | 1 | AD driver enable |
| devsel_n | output | 1 | DEVSEL# value |
| devsel_oe | output | 1 | DEVSEL# enable |
| trdy_n | output | 1 | TRDY# value |
| trdy_oe | output | 1 | TRDY# enable |
| stop_n | output | 1 | STOP# value |
| stop_oe | output | 1 | STOP# enable |
| sel_n | output | 1 | Memory-path select, active low |
| cpu_addr_oe_n | output | 1 | CPU address output enable, active low |
| aack_n | output | 1 | Address acknowledge value |
| aack_oe | output | 1 | Address acknowledge enable |

## Verification
The properties rely on three assumptions about the inputs:
- keep_grant is a settled level on the release edge.
- FRAME# starts a transaction only when it is seen by an idle block.
- LAT is at least 1.

The stimulus follows these assumptions. It drives FRAME# low for a single clock per transaction, together with a decode level. It keeps mem_data steady until the data edge has passed. It changes keep_grant only at mid-cycle. It does pull FRAME# low again inside a running transaction, to show that such a pulse is ignored. Every transaction runs through its release edge before the next one starts.

// File: rtl/pci_tgt_rd_seq.sv
module pci_tgt_rd_seq #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          addr_hit,
  input  logic          keep_grant,
  input  logic [AW-1:0] ad_in,
  input  logic [DW-1:0] mem_data,
  output logic          adsel,
  output logic [AW-1:0] ad_q,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          devsel_n,
  output logic          devsel_oe,
  output logic          trdy_n,
  output logic          trdy_oe,
  output logic          stop_n,
  output logic          stop_oe,
  output logic          sel_n,
  output logic          cpu_addr_oe_n,
  output logic          aack_n,
  output logic          aack_oe
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_WAIT, S_DATA, S_RECOV} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          tgt_oe;
  logic          hs_oe;

  assign stop_n    = 1'b1;
  assign aack_n    = 1'b1;
  assign devsel_oe = tgt_oe;
  assign trdy_oe   = hs_oe;
  assign stop_oe   = hs_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) ad_q <= '0;
    else if (adsel) ad_q <= ad_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cnt           <= '0;
      adsel         <= 1'b1;
      tgt_oe        <= 1'b0;
      hs_oe         <= 1'b0;
      devsel_n      <= 1'b1;
      trdy_n        <= 1'b1;
      ad_oe         <= 1'b0;
      ad_out        <= '0;
      sel_n         <= 1'b1;
      cpu_addr_oe_n <= 1'b1;
      aack_oe       <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!frame_n && addr_hit) begin
          adsel <= 1'b0;
          st    <= S_TURN;
        end
        S_TURN: begin
          tgt_oe        <= 1'b1;
          hs_oe         <= 1'b1;
          devsel_n      <= 1'b0;
          trdy_n        <= 1'b1;
          ad_oe         <= 1'b1;
          sel_n         <= 1'b0;
          cpu_addr_oe_n <= 1'b0;
          aack_oe       <= 1'b1;
          cnt           <= CW'(LAT - 1);
          st            <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == '0) begin
            trdy_n <= 1'b0;
            ad_out <= mem_data;
            st     <= S_DATA;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DATA: begin
          trdy_n   <= 1'b1;
          devsel_n <= 1'b1;
          ad_oe    <= 1'b0;
          st       <= S_RECOV;
        end
        S_RECOV: begin
          tgt_oe <= 1'b0;
          hs_oe  <= 1'b0;
          adsel  <= 1'b1;
          st     <= S_IDLE;
          if (!keep_grant) begin
            sel_n         <= 1'b1;
            cpu_addr_oe_n <= 1'b1;
            aack_oe       <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_tgt_rd_seq_chk.sv
module pci_tgt_rd_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          keep_grant,
  input logic          adsel,
  input logic [AW-1:0] ad_q,
  input logic          ad_oe,
  input logic          devsel_n,
  input logic          devsel_oe,
  input logic          trdy_n,
  input logic          trdy_oe,
  input logic          sel_n,
  input logic          cpu_addr_oe_n,
  input logic          aack_oe
);
  a_r2_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(adsel) |-> $stable(ad_q));

  a_r5_trdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_n) |=> trdy_n);

  a_r5_trdy_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_n) |-> (devsel_oe && !devsel_n && ad_oe && !adsel));

  a_r6_ad_off_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ad_oe) |=> $fell(trdy_oe));

  a_r7_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_oe) |-> (adsel && !devsel_oe));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(trdy_oe) && $past(keep_grant)) |-> (!sel_n && !cpu_addr_oe_n && aack_oe));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(trdy_oe) && !$past(keep_grant)) |-> (sel_n && cpu_addr_oe_n && !aack_oe));

  a_r10_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (adsel && $past(adsel)) |-> (!ad_oe && !(trdy_oe && !trdy_n)));
endmodule

bind pci_tgt_rd_seq pci_tgt_rd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .keep_grant(keep_grant), .adsel(adsel), .ad_q(ad_q),
  .ad_oe(ad_oe), .devsel_n(devsel_n), .devsel_oe(devsel_oe), .trdy_n(trdy_n),
  .trdy_oe(trdy_oe), .sel_n(sel_n), .cpu_addr_oe_n(cpu_addr_oe_n), .aack_oe(aack_oe)
);

// File: tb/sim_pci_tgt_rd_seq.sv
module sim_pci_tgt_rd_seq;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n, frame_n, addr_hit, keep_grant;
  logic [31:0] ad_in, mem_data, ad_q, ad_out;
  logic adsel, ad_oe, devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe;
  logic sel_n, cpu_addr_oe_n, aack_n, aack_oe;

  always #5 clk = ~clk;

  pci_tgt_rd_seq #(.AW(32), .DW(32), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .addr_hit(addr_hit),
    .keep_grant(keep_grant), .ad_in(ad_in), .mem_data(mem_data),
    .adsel(adsel), .ad_q(ad_q), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .devsel_oe(devsel_oe), .trdy_n(trdy_n), .trdy_oe(trdy_oe),
    .stop_n(stop_n), .stop_oe(stop_oe), .sel_n(sel_n), .cpu_addr_oe_n(cpu_addr_oe_n),
    .aack_n(aack_n), .aack_oe(aack_oe)
  );

  typedef struct {logic [31:0] a; logic [31:0] d;} item_t;
  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && trdy_oe === 1'b1 && trdy_n === 1'b0) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected data beat", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(ad_out == it.d, "R5 data word", ad_out, it.d);
        check(ad_q == it.a, "R2 address held at beat", ad_q, it.a);
        check(ad_oe == 1'b1, "R5 AD driven at beat", ad_oe, 1);
      end
    end
  end

  task automatic run_txn(input logic [31:0] a, input logic [31:0] d,
                         input bit hit, input bit keep, input bit retrig);
    @(negedge clk);
    frame_n = 1'b0; ad_in = a; addr_hit = hit; mem_data = d; keep_grant = !keep;
    if (hit) sb.push_back('{a: a, d: d});
    for (int e = 1; e <= LAT + 4; e++) begin
      @(negedge clk);
      if (e == 1) begin
        check(ad_q == a, "R2 capture", ad_q, a);
        check(adsel == !hit, "R3 adsel after frame", adsel, !hit);
        frame_n = 1'b1; ad_in = ~a;
      end
      if (!hit) begin
        check(!(devsel_oe | trdy_oe | stop_oe | ad_oe) && adsel, "R10 stays idle",
              {devsel_oe, trdy_oe, stop_oe, ad_oe, adsel}, 5'b00001);
        if (e == 2) check(ad_q == ~a, "R2 latch follows", ad_q, ~a);
      end else begin
        if (e == 2) begin
          check(devsel_oe && !devsel_n, "R4 devsel claim", {devsel_oe, devsel_n}, 2'b10);
          check(trdy_oe && trdy_n && stop_oe && stop_n, "R4 trdy/stop high",
                {trdy_oe, trdy_n, stop_oe, stop_n}, 4'hf);
          check(ad_oe, "R4 ad_oe on", ad_oe, 1);
          check(!sel_n && !cpu_addr_oe_n && aack_oe && aack_n, "R4 shared controls",
                {sel_n, cpu_addr_oe_n, aack_oe, aack_n}, 4'b0011);
          check(ad_q == a, "R2 latch frozen", ad_q, a);
          keep_grant = keep;
        end
        if (retrig && e == 3) begin frame_n = 1'b0; ad_in = 32'h0bad_0bad; end
        if (retrig && e == 4) frame_n = 1'b1;
        if (e >= 2 && e < 2 + LAT) check(trdy_n == 1'b1, "R5 no early trdy", trdy_n, 1);
        if (e == 2 + LAT) begin
          check(trdy_n == 1'b0, "R5 trdy asserted", trdy_n, 0);
          mem_data = ~d;
          keep_grant = !keep;
        end
        if (e == 3 + LAT) begin
          check(trdy_oe && trdy_n && devsel_oe && devsel_n && stop_oe && stop_n,
                "R6 handshake high", {trdy_oe, trdy_n, devsel_oe, devsel_n, stop_oe, stop_n}, 6'h3f);
          check(!ad_oe, "R6 ad_oe off", ad_oe, 0);
          check(!sel_n && aack_oe, "R11 grant ignored mid-cycle", {sel_n, aack_oe}, 2'b01);
          keep_grant = keep;
        end
        if (e == 4 + LAT) begin
          check(!(trdy_oe | devsel_oe | stop_oe), "R7 float", {trdy_oe, devsel_oe, stop_oe}, 0);
          check(adsel, "R7 adsel back", adsel, 1);
          if (keep)
            check(!sel_n && !cpu_addr_oe_n && aack_oe && aack_n, "R8 keep grant",
                  {sel_n, cpu_addr_oe_n, aack_oe, aack_n}, 4'b0011);
          else
            check(sel_n && cpu_addr_oe_n && !aack_oe, "R9 lose grant",
                  {sel_n, cpu_addr_oe_n, aack_oe}, 3'b110);
        end
      end
    end
    ad_in = a ^ 32'h5555_5555;
    @(negedge clk);
    check(adsel && !devsel_oe && !trdy_oe, "R11 no restart",
          {adsel, devsel_oe, trdy_oe}, 3'b100);
    check(ad_q == (a ^ 32'h5555_5555), "R2 latch reopened", ad_q, a ^ 32'h5555_5555);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R5 watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; addr_hit = 1'b0; keep_grant = 1'b0;
    ad_in = 32'h1111_2222; mem_data = '0;
    repeat (3) @(negedge clk);
    check(adsel && !ad_oe && !devsel_oe && !trdy_oe && !stop_oe && !aack_oe,
          "R1 reset enables", {adsel, ad_oe, devsel_oe, trdy_oe, stop_oe, aack_oe}, 6'b100000);
    check(sel_n && cpu_addr_oe_n, "R1 reset selects", {sel_n, cpu_addr_oe_n}, 2'b11);
    rst_n = 1'b1;
    run_txn(32'h0000_1000, 32'hcafe_0001, 1'b1, 1'b0, 1'b0);
    run_txn(32'h0000_2004, 32'hcafe_0002, 1'b1, 1'b1, 1'b0);
    run_txn(32'h8000_0008, 32'h1234_5678, 1'b0, 1'b1, 1'b0);
    run_txn(32'hffff_fffc, 32'h0000_0000, 1'b1, 1'b1, 1'b1);
    run_txn(32'h0000_0000, 32'hffff_ffff, 1'b1, 1'b0, 1'b1);
    run_txn(32'ha5a5_a5a4, 32'h5a5a_5a5a, 1'b0, 1'b0, 1'b0);
    run_txn(32'h0f0f_0f00, 32'hdead_beef, 1'b1, 1'b0, 1'b0);
    check(sb.size() == 0, "R5 all beats delivered", sb.size(), 0);
    summary();
    $finish;
  end
endmodule